// File: doc/BRIEF.md
# Request deadline tag generator

This block gives every memory read request from an image-capture requester a deadline. The deadline is a timestamp on the same scale as a free-running global timer. It keeps a running "next deadline" value. Each accepted request gets the larger of two values: that running value, or the timer plus a programmable minimum lead. The running value then moves forward by a programmable increment, and by twice the increment for a 64-byte request. All times are 32-bit counts of 1/1024 µs ticks. A 250 ns configuration unit is 256 ticks, and the far-future window of 64 µs is 65536 ticks. Every time comparison uses wrap-safe subtraction: a is "after" b when the difference a−b, read as a signed number, is positive.

A small state machine with three states handles wakeups: SEED, RUN and DRAIN. SEED loads the running value with the timer plus the first-request delay and is the state after reset. RUN accepts requests. A rising edge on the wakeup input moves SEED or RUN into DRAIN, unless wakeups are set to be ignored. DRAIN stalls the requester until no reads are outstanding and all FIFOs are empty, then goes to SEED. SEED always goes to RUN on the next cycle, unless a new wakeup edge sends it back to DRAIN.

A separate guard stalls the requester whenever the running value is more than 64 µs ahead of the timer, unless that check is switched off. Configuration inputs are read in the cycle a request is accepted.

Top module: `dl_tagger`

## Requirements
- R1: During reset and in the first cycle after it, stall_o is 1. The first clock edge after reset loads the running value with timer_i + cfg_first_dly_i×256, and stall_o is 0 from then on, unless another stall source is active.
- R2: After an accepted request with req_wide_i=0 (32-byte), the running value becomes the issued deadline + cfg_incr_i.
- R3: After an accepted request with req_wide_i=1 (64-byte), the running value becomes the issued deadline + 2×cfg_incr_i.
- R4: The issued deadline is the running value, unless timer_i + cfg_min_lead_i×256 lies after it in the wrap-safe sense. In that case the issued deadline is timer_i + cfg_min_lead_i×256.
- R5: deadline_vld_o equals req_valid_i AND NOT stall_o, and deadline_o carries the issued deadline in that same cycle.
- R6: With cfg_wake_ignore_i=0, a rising edge of wake_i seen at a clock edge in RUN moves to DRAIN. stall_o is 1 from the next cycle on, and it stays 1 while inflight_i≠0 or fifos_empty_i=0.
- R7: Once DRAIN sees inflight_i=0 and fifos_empty_i=1, it spends one stalled SEED cycle. At the end of that cycle the running value is loaded with timer_i + cfg_first_dly_i×256, sampled at that edge, and the stall is released.
- R8: A new wake_i rising edge seen during DRAIN or SEED keeps or returns the machine to DRAIN. The drain wait starts over and no deadline is issued.
- R9: With cfg_wake_ignore_i=1, wake_i edges change neither stall_o nor the running value.
- R10: With cfg_far_chk_off_i=0, stall_o is 1 whenever the running value minus (timer_i + 65536) is positive as a signed number. A difference of exactly zero does not stall.
- R11: With cfg_far_chk_off_i=1, the far-future check never stalls.
- R12: A configuration change between two requests affects only the requests accepted after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_i | input | 32 | Global timer, 1/1024 µs ticks |
| wake_i | input | 1 | Wakeup level; its rising edge starts a drain |
| req_valid_i | input | 1 | Requester has a read request |
| req_wide_i | input | 1 | 1 = 64-byte request, 0 = 32-byte request |
| inflight_i | input | 8 | Number of reads still outstanding |
| fifos_empty_i | input | 1 | All FIFOs are empty |
| cfg_first_dly_i | input | 8 | First-request delay, 250 ns units |
| cfg_incr_i | input | 8 | Per-32-byte increment, 1/1024 µs units |
| cfg_min_lead_i | input | 4 | Minimum lead over the timer, 250 ns units |
| cfg_wake_ignore_i | input | 1 | 1 = ignore wake_i |
| cfg_far_chk_off_i | input | 1 | 1 = disable the 64 µs far-future stall |
| stall_o | output | 1 | Requester must hold its request |
| deadline_vld_o | output | 1 | A request is accepted this cycle |
| deadline_o | output | 32 | Deadline for the accepted request |

## Verification
The assertions check on every cycle that:
- an accepted deadline never falls short of the minimum lead;
- with the check enabled, an accepted deadline never lies beyond the 64 µs window;
- DRAIN holds while reads or FIFO data remain;
- SEED never lasts two cycles;
- ignored wakeups leave RUN alone;
- a wakeup edge in RUN always leads to DRAIN;
- each accepted request moves the running value forward.

Only the bench scenarios can show the exact deadline values. These cover the seed value after reset and after a drain, the 32-byte and 64-byte increments, clamping, and the far-window boundary at exactly 64 µs. They also show the extra stalled cycle caused by a wakeup edge during DRAIN.

// File: rtl/dl_pkg.sv
package dl_pkg;

    // Wakeup sequencing states
    typedef enum logic [1:0] {
        ST_SEED  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } dl_state_e;

endpackage

// File: rtl/dl_wake_fsm.sv
module dl_wake_fsm
    import dl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_i,
    input  logic             ignore_i,
    input  logic [CNT_W-1:0] inflight_i,
    input  logic             fifos_empty_i,
    output logic             seed_o,
    output logic             hold_o
);

    dl_state_e state_q, state_d;
    logic      wake_q;
    logic      wake_edge;
    logic      drained;

    assign wake_edge = wake_i & ~wake_q & ~ignore_i;
    assign drained   = (inflight_i == '0) && fifos_empty_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_i;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED:  state_d = wake_edge ? ST_DRAIN : ST_RUN;
            ST_RUN:   state_d = wake_edge ? ST_DRAIN : ST_RUN;
            ST_DRAIN: state_d = (drained && !wake_edge) ? ST_SEED : ST_DRAIN;
            default:  state_d = ST_SEED;
        endcase
    end

    // Outputs
    always_comb begin
        seed_o = 1'b0;
        hold_o = 1'b1;
        unique case (state_q)
            ST_SEED:  begin seed_o = 1'b1; hold_o = 1'b1; end
            ST_RUN:   begin seed_o = 1'b0; hold_o = 1'b0; end
            ST_DRAIN: begin seed_o = 1'b0; hold_o = 1'b1; end
            default:  begin seed_o = 1'b0; hold_o = 1'b1; end
        endcase
    end

    // R6: drain holds while anything is outstanding
    a_r6_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !((inflight_i == '0) && fifos_empty_i))
        |=> state_q == ST_DRAIN);

    // R6: a honoured wakeup edge in RUN always enters DRAIN
    a_r6_enter_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wake_i && !wake_q && !ignore_i)
        |=> state_q == ST_DRAIN);

    // R7: seeding lasts exactly one cycle
    a_r7_seed_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED) |=> state_q != ST_SEED);

    // R9: ignored wakeups leave RUN untouched
    a_r9_ignore_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ignore_i) |=> state_q == ST_RUN);

endmodule

// File: rtl/dl_calc.sv
module dl_calc #(
    parameter int TS_W    = 32,
    parameter int FD_W    = 8,
    parameter int INC_W   = 8,
    parameter int MIN_W   = 4,
    parameter int UNIT_SH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  timer_i,
    input  logic [FD_W-1:0]  first_dly_i,
    input  logic [INC_W-1:0] incr_i,
    input  logic [MIN_W-1:0] min_lead_i,
    input  logic             wide_i,
    input  logic             accept_i,
    input  logic             seed_i,
    output logic [TS_W-1:0]  issued_o,
    output logic [TS_W-1:0]  next_o
);

    localparam int FD_PAD  = TS_W - FD_W - UNIT_SH;
    localparam int MIN_PAD = TS_W - MIN_W - UNIT_SH;
    localparam int INC_PAD = TS_W - INC_W;

    logic [TS_W-1:0] next_q;
    logic [TS_W-1:0] first_ext, lead_ext, inc_ext, step;
    logic [TS_W-1:0] lead_at, gap;

    assign first_ext = {{FD_PAD{1'b0}},  first_dly_i, {UNIT_SH{1'b0}}};
    assign lead_ext  = {{MIN_PAD{1'b0}}, min_lead_i,  {UNIT_SH{1'b0}}};
    assign inc_ext   = {{INC_PAD{1'b0}}, incr_i};
    assign step      = wide_i ? (inc_ext << 1) : inc_ext;

    // Clamp to the minimum lead over the timer (wrap-safe)
    assign lead_at  = timer_i + lead_ext;
    assign gap      = next_q - lead_at;
    assign issued_o = gap[TS_W-1] ? lead_at : next_q;
    assign next_o   = next_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
        end else if (seed_i) begin
            next_q <= timer_i + first_ext;
        end else if (accept_i) begin
            next_q <= issued_o + step;
        end
    end

    // R2 / R3: each accepted request moves the running value forward
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !seed_i && incr_i != '0) |=> next_q != $past(issued_o));

endmodule

// File: rtl/dl_guard.sv
module dl_guard #(
    parameter int TS_W   = 32,
    parameter int WIN_SH = 16
) (
    input  logic [TS_W-1:0] next_i,
    input  logic [TS_W-1:0] timer_i,
    input  logic            chk_off_i,
    output logic            far_o
);

    localparam logic [TS_W-1:0] WINDOW = {{(TS_W-1){1'b0}}, 1'b1} << WIN_SH;

    logic [TS_W-1:0] limit;
    logic [TS_W-1:0] diff;

    assign limit = timer_i + WINDOW;
    assign diff  = next_i - limit;
    // Beyond the window when the signed difference is strictly positive
    assign far_o = !chk_off_i && !diff[TS_W-1] && (diff != '0);

endmodule

// File: rtl/dl_tagger.sv
module dl_tagger
    import dl_pkg::*;
#(
    parameter int TS_W    = 32,
    parameter int CNT_W   = 8,
    parameter int FD_W    = 8,
    parameter int INC_W   = 8,
    parameter int MIN_W   = 4,
    parameter int UNIT_SH = 8,
    parameter int WIN_SH  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  timer_i,
    input  logic             wake_i,
    input  logic             req_valid_i,
    input  logic             req_wide_i,
    input  logic [CNT_W-1:0] inflight_i,
    input  logic             fifos_empty_i,
    input  logic [FD_W-1:0]  cfg_first_dly_i,
    input  logic [INC_W-1:0] cfg_incr_i,
    input  logic [MIN_W-1:0] cfg_min_lead_i,
    input  logic             cfg_wake_ignore_i,
    input  logic             cfg_far_chk_off_i,
    output logic             stall_o,
    output logic             deadline_vld_o,
    output logic [TS_W-1:0]  deadline_o
);

    localparam int MIN_PAD = TS_W - MIN_W - UNIT_SH;
    localparam logic [TS_W-1:0] WINDOW = {{(TS_W-1){1'b0}}, 1'b1} << WIN_SH;

    logic            seed, hold, far, accept;
    logic [TS_W-1:0] issued, next_val;

    dl_wake_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wake_i        (wake_i),
        .ignore_i      (cfg_wake_ignore_i),
        .inflight_i    (inflight_i),
        .fifos_empty_i (fifos_empty_i),
        .seed_o        (seed),
        .hold_o        (hold)
    );

    dl_calc #(
        .TS_W(TS_W), .FD_W(FD_W), .INC_W(INC_W),
        .MIN_W(MIN_W), .UNIT_SH(UNIT_SH)
    ) u_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer_i     (timer_i),
        .first_dly_i (cfg_first_dly_i),
        .incr_i      (cfg_incr_i),
        .min_lead_i  (cfg_min_lead_i),
        .wide_i      (req_wide_i),
        .accept_i    (accept),
        .seed_i      (seed),
        .issued_o    (issued),
        .next_o      (next_val)
    );

    dl_guard #(.TS_W(TS_W), .WIN_SH(WIN_SH)) u_guard (
        .next_i    (next_val),
        .timer_i   (timer_i),
        .chk_off_i (cfg_far_chk_off_i),
        .far_o     (far)
    );

    assign stall_o        = hold | far;
    assign accept         = req_valid_i & ~stall_o;
    assign deadline_vld_o = accept;
    assign deadline_o     = issued;

    // Checker views computed from the ports
    logic [TS_W-1:0] min_gap, far_gap;
    assign min_gap = deadline_o - (timer_i + {{MIN_PAD{1'b0}}, cfg_min_lead_i, {UNIT_SH{1'b0}}});
    assign far_gap = deadline_o - (timer_i + WINDOW);

    // R4: no accepted deadline falls short of the minimum lead
    a_r4_min_lead: assert property (@(posedge clk) disable iff (!rst_n)
        deadline_vld_o |-> !min_gap[TS_W-1]);

    // R10: with the check on, no accepted deadline lies beyond the window
    a_r10_far_window: assert property (@(posedge clk) disable iff (!rst_n)
        (deadline_vld_o && !cfg_far_chk_off_i) |-> (far_gap[TS_W-1] || far_gap == '0));

endmodule

// File: tb/dl_tagger_tb_top.sv
module dl_tagger_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] timer_i;
    logic        wake_i, req_valid_i, req_wide_i, fifos_empty_i;
    logic [7:0]  inflight_i, cfg_first_dly_i, cfg_incr_i;
    logic [3:0]  cfg_min_lead_i;
    logic        cfg_wake_ignore_i, cfg_far_chk_off_i;
    logic        stall_o, deadline_vld_o;
    logic [31:0] deadline_o;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_q[$];
    logic [31:0] model_next;
    bit          done = 0;

    always #(CLK_P/2) clk = ~clk;

    dl_tagger dut_i (
        .clk(clk), .rst_n(rst_n), .timer_i(timer_i), .wake_i(wake_i),
        .req_valid_i(req_valid_i), .req_wide_i(req_wide_i),
        .inflight_i(inflight_i), .fifos_empty_i(fifos_empty_i),
        .cfg_first_dly_i(cfg_first_dly_i), .cfg_incr_i(cfg_incr_i),
        .cfg_min_lead_i(cfg_min_lead_i), .cfg_wake_ignore_i(cfg_wake_ignore_i),
        .cfg_far_chk_off_i(cfg_far_chk_off_i), .stall_o(stall_o),
        .deadline_vld_o(deadline_vld_o), .deadline_o(deadline_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one request cycle, expectation from the requirement formulas
    task automatic send(input bit wide);
        logic [31:0] lead, gap, issue, step;
        lead  = timer_i + {20'd0, cfg_min_lead_i, 8'd0};
        gap   = model_next - lead;
        issue = gap[31] ? lead : model_next;
        step  = wide ? {23'd0, cfg_incr_i, 1'b0} : {24'd0, cfg_incr_i};
        model_next = issue + step;
        exp_q.push_back(issue);
        req_valid_i = 1'b1;
        req_wide_i  = wide;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // Monitor: pops expected deadlines as the design accepts requests
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (deadline_vld_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected accept", deadline_o, 32'd0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(deadline_o == e, "R2/R3/R4/R12 deadline", deadline_o, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_P*100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; timer_i = 32'd1000; wake_i = 0; req_valid_i = 0; req_wide_i = 0;
        inflight_i = 0; fifos_empty_i = 1; cfg_first_dly_i = 8'd4; cfg_incr_i = 8'd10;
        cfg_min_lead_i = 4'd1; cfg_wake_ignore_i = 0; cfg_far_chk_off_i = 0;
        model_next = 32'd0;
        repeat (3) @(negedge clk);
        chk(stall_o == 1'b1, "R1 stall in reset", {31'd0, stall_o}, 32'd1);
        rst_n = 1;
        #1;
        chk(stall_o == 1'b1, "R1 stall before seed", {31'd0, stall_o}, 32'd1);
        @(negedge clk);
        chk(stall_o == 1'b0, "R1 stall after seed", {31'd0, stall_o}, 32'd0);
        model_next = 32'd1000 + 32'd1024;

        // R2, R3: increments; R12: config changed between requests
        send(1'b0);
        send(1'b1);
        cfg_incr_i = 8'd20;
        send(1'b0);

        // R4: clamping to the minimum lead
        timer_i = 32'd5000;
        send(1'b0);
        cfg_min_lead_i = 4'd3;
        send(1'b1);
        cfg_min_lead_i = 4'd1;

        // R10: boundary at exactly the window, then one tick past it
        timer_i = model_next - 32'd65536;
        #1;
        chk(stall_o == 1'b0, "R10 equal window no stall", {31'd0, stall_o}, 32'd0);
        @(negedge clk);
        timer_i = model_next - 32'd65537;
        req_valid_i = 1'b1;
        #1;
        chk(stall_o == 1'b1, "R10 beyond window stalls", {31'd0, stall_o}, 32'd1);
        chk(deadline_vld_o == 1'b0, "R5 no accept while stalled", {31'd0, deadline_vld_o}, 32'd0);
        @(negedge clk);
        req_valid_i = 1'b0;
        // R11: check disabled
        cfg_far_chk_off_i = 1'b1;
        #1;
        chk(stall_o == 1'b0, "R11 far check off", {31'd0, stall_o}, 32'd0);
        @(negedge clk);
        send(1'b0);
        cfg_far_chk_off_i = 1'b0;
        timer_i = 32'd20000;

        // R6, R7: wakeup drain and reseed
        cfg_first_dly_i = 8'd8;
        inflight_i = 8'd2; fifos_empty_i = 0; wake_i = 1;
        @(negedge clk);
        wake_i = 0;
        req_valid_i = 1'b1;
        #1;
        chk(stall_o == 1'b1, "R6 stall after wake", {31'd0, stall_o}, 32'd1);
        chk(deadline_vld_o == 1'b0, "R6 no accept in drain", {31'd0, deadline_vld_o}, 32'd0);
        @(negedge clk);
        req_valid_i = 1'b0;
        inflight_i = 8'd0;
        @(negedge clk);
        chk(stall_o == 1'b1, "R6 hold while fifos busy", {31'd0, stall_o}, 32'd1);
        fifos_empty_i = 1;
        @(negedge clk);
        chk(stall_o == 1'b1, "R7 seed cycle stalled", {31'd0, stall_o}, 32'd1);
        @(negedge clk);
        chk(stall_o == 1'b0, "R7 stall released", {31'd0, stall_o}, 32'd0);
        model_next = 32'd20000 + 32'd2048;
        send(1'b0);

        // R8: wakeup edge during drain restarts the wait
        timer_i = 32'd30000;
        inflight_i = 8'd1; wake_i = 1;
        @(negedge clk);
        wake_i = 0;
        @(negedge clk);
        wake_i = 1; inflight_i = 8'd0;
        @(negedge clk);
        wake_i = 0;
        chk(stall_o == 1'b1, "R8 still draining", {31'd0, stall_o}, 32'd1);
        @(negedge clk);
        chk(stall_o == 1'b1, "R8 restart adds a cycle", {31'd0, stall_o}, 32'd1);
        @(negedge clk);
        chk(stall_o == 1'b0, "R8 released after seed", {31'd0, stall_o}, 32'd0);
        chk(exp_q.size() == 0, "R8 no extra deadline", exp_q.size(), 32'd0);
        model_next = 32'd30000 + 32'd2048;
        send(1'b1);

        // R9: ignored wakeup
        cfg_wake_ignore_i = 1; inflight_i = 8'd3; fifos_empty_i = 0; wake_i = 1;
        @(negedge clk);
        wake_i = 0;
        #1;
        chk(stall_o == 1'b0, "R9 wake ignored", {31'd0, stall_o}, 32'd0);
        @(negedge clk);
        send(1'b0);
        cfg_wake_ignore_i = 0;

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all requests accepted", exp_q.size(), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule